// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This controller sits beside the decode stage of a five-stage in-order integer pipeline and decides, every cycle, where the two source operands of the instruction being decoded should come from. It compares the decode instruction's two source register numbers with the destination number and write enable carried by the execute, memory and writeback pipeline registers. From that comparison it produces one bypass select per operand, a raw-hazard indication, and an interlock (fetch hold plus execute bubble) for the case where a load's result is needed before it exists.

The register file writes in the first half of the cycle and is read in the second half. An instruction in writeback therefore never needs a bypass; it is still reported as a hazard. A store whose data register is loaded by the instruction just ahead of it does not stall. Instead, a flag follows the store and tells the memory-stage data mux to take the loaded word when the store reaches that stage. The pipeline is assumed to advance every cycle except while this block holds it.

Top module: `raw_bypass_ctl`

## Requirements
- R1: A source register matches a stage only when the decode instruction is valid, the source is marked as used, the source number is nonzero, it equals that stage's destination, and that stage's write enable is high. Register 0 or a cleared enable or use flag never forwards, never raises raw_hazard and never stalls.
- R2: raw_hazard is high when either source matches any of the execute, memory or writeback stages.
- R3: Select encoding is 2'b00 register file, 2'b01 execute result, 2'b10 memory result. A match in execute by a non-load gives 2'b01 even when memory also matches; a memory match alone gives 2'b10; the value 2'b11 never appears.
- R4: A match found only in writeback leaves the select at 2'b00.
- R5: When execute holds a load (ex_load high) and either source matches it, except a store's data source (rt), stall_fetch and bubble_ex rise together in that same cycle and the select of the matching operand is 2'b00.
- R6: The interlock lasts one cycle. In the cycle after a stall, stall_fetch is low even if the inputs still describe a load-use case.
- R7: A valid store (id_store high, data in rt) whose rt matches a load in execute, and whose rs does not, does not stall; mem_store_byp is high exactly two cycles later, and low otherwise.
- R8: A store whose address source rs matches a load in execute stalls as in R5 and produces no mem_store_byp pulse.
- R9: With id_valid low, both selects are 2'b00 and raw_hazard, stall_fetch and bubble_ex are low.
- R10: While rst_n is low and in the first cycle after it, mem_store_byp and stall_fetch history are cleared, so no pulse from before reset appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs | input | 5 | First source register number |
| id_rt | input | 5 | Second source register number (store data for stores) |
| id_use_rs | input | 1 | First source is read |
| id_use_rt | input | 1 | Second source is read |
| id_store | input | 1 | Decode instruction is a store |
| ex_dst | input | 5 | Destination register in execute |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | 5 | Destination register in memory stage |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Destination register in writeback |
| wb_wen | input | 1 | Writeback instruction writes a register |
| fwd_sel_a | output | 2 | Bypass select for rs operand |
| fwd_sel_b | output | 2 | Bypass select for rt operand |
| raw_hazard | output | 1 | Some source depends on an in-flight write |
| stall_fetch | output | 1 | Hold PC and decode register |
| bubble_ex | output | 1 | Insert a no-op into execute |
| mem_store_byp | output | 1 | Memory stage takes store data from the load result |

## Verification
The selects, raw_hazard, stall_fetch and bubble_ex are due in the same cycle as the decode inputs that cause them, so each is sampled one nanosecond after the falling edge on which the vector was driven. mem_store_byp is due two rising edges after its store is decoded, and the single-cycle interlock depends on the previous cycle. The scoreboard therefore keeps a two-deep history of store-bypass events and the previous stall, and it compares each popped item with the outputs in the cycle the item belongs to.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_EX  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        logic ex;
        logic mem;
        logic wb;
    } stage_hit_t;

    typedef struct packed {
        logic stall;
        logic ex_byp;
        logic mem_byp;
    } track_t;

endpackage

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp #(
    parameter int REG_W = 5
) (
    input  logic             valid,
    input  logic             use_src,
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wen,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wen,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wen,
    output hzd_pkg::stage_hit_t hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic live;

    always_comb begin
        live    = valid && use_src && (src != ZERO_REG);
        hit.ex  = live && ex_wen  && (src == ex_dst);
        hit.mem = live && mem_wen && (src == mem_dst);
        hit.wb  = live && wb_wen  && (src == wb_dst);
    end
endmodule

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick (
    input  hzd_pkg::stage_hit_t hit,
    input  logic                ex_load,
    output hzd_pkg::fwd_sel_e   sel,
    output logic                load_dep
);
    import hzd_pkg::*;

    always_comb begin
        load_dep = hit.ex && ex_load;
        if (hit.ex) begin
            // nearest writer wins; a load's value is not ready yet
            sel = ex_load ? FWD_RF : FWD_EX;
        end else if (hit.mem) begin
            sel = FWD_MEM;
        end else begin
            sel = FWD_RF;
        end
    end
endmodule

// File: rtl/hzd_track.sv
module hzd_track (
    input  logic clk,
    input  logic rst_n,
    input  logic lu_raw,
    input  logic st_cand,
    output logic stall,
    output logic mem_byp
);
    import hzd_pkg::*;

    track_t st_q;
    track_t st_d;

    always_comb begin
        st_d         = st_q;
        st_d.stall   = lu_raw && !st_q.stall;
        // a stalled decode instruction does not move; a bubble enters execute
        st_d.ex_byp  = st_cand && !st_d.stall;
        st_d.mem_byp = st_q.ex_byp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall   = st_d.stall;
    assign mem_byp = st_q.mem_byp;

    p_stall_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    p_byp_two_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_byp |-> $past(st_cand, 2));
endmodule

// File: rtl/raw_bypass_ctl.sv
module raw_bypass_ctl #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [REG_W-1:0] id_rs,
    input  logic [REG_W-1:0] id_rt,
    input  logic             id_use_rs,
    input  logic             id_use_rt,
    input  logic             id_store,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_wen,
    input  logic             ex_load,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_wen,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_wen,
    output logic [1:0]       fwd_sel_a,
    output logic [1:0]       fwd_sel_b,
    output logic             raw_hazard,
    output logic             stall_fetch,
    output logic             bubble_ex,
    output logic             mem_store_byp
);
    import hzd_pkg::*;

    localparam int NSRC  = 2;
    localparam int SRC_A = 0;
    localparam int SRC_B = 1;

    logic [NSRC-1:0][REG_W-1:0] src_num;
    logic [NSRC-1:0]            src_use;
    stage_hit_t                 hit      [NSRC];
    fwd_sel_e                   sel      [NSRC];
    logic [NSRC-1:0]            load_dep;
    logic [NSRC-1:0]            any_hit;
    logic                       lu_raw;
    logic                       st_cand;
    logic                       stall;

    assign src_num = {id_rt, id_rs};
    assign src_use = {id_use_rt, id_use_rs};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hzd_src_cmp #(.REG_W(REG_W)) u_cmp (
            .valid   (id_valid),
            .use_src (src_use[g]),
            .src     (src_num[g]),
            .ex_dst  (ex_dst),
            .ex_wen  (ex_wen),
            .mem_dst (mem_dst),
            .mem_wen (mem_wen),
            .wb_dst  (wb_dst),
            .wb_wen  (wb_wen),
            .hit     (hit[g])
        );

        hzd_fwd_pick u_pick (
            .hit      (hit[g]),
            .ex_load  (ex_load),
            .sel      (sel[g]),
            .load_dep (load_dep[g])
        );

        assign any_hit[g] = hit[g].ex || hit[g].mem || hit[g].wb;
    end

    always_comb begin
        // store data is served later in the memory stage, not by interlock
        lu_raw  = load_dep[SRC_A] || (load_dep[SRC_B] && !id_store);
        st_cand = id_store && load_dep[SRC_B] && !load_dep[SRC_A];
    end

    hzd_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .lu_raw  (lu_raw),
        .st_cand (st_cand),
        .stall   (stall),
        .mem_byp (mem_store_byp)
    );

    assign fwd_sel_a   = sel[SRC_A];
    assign fwd_sel_b   = sel[SRC_B];
    assign raw_hazard  = |any_hit;
    assign stall_fetch = stall;
    assign bubble_ex   = stall;

    p_zero_reg_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs == '0) |-> (fwd_sel_a == 2'b00));

    p_sel_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a != 2'b11) && (fwd_sel_b != 2'b11));

    p_stall_needs_hazard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_fetch |-> (raw_hazard && ex_load));

    p_store_no_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_cand |-> !stall_fetch);

    p_invalid_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> (!raw_hazard && !stall_fetch && fwd_sel_b == 2'b00));
endmodule

// File: tb/tb_raw_bypass_ctl.sv
`timescale 1ns/1ps
module tb_raw_bypass_ctl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       id_valid, id_use_rs, id_use_rt, id_store;
    logic [4:0] id_rs, id_rt, ex_dst, mem_dst, wb_dst;
    logic       ex_wen, ex_load, mem_wen, wb_wen;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic       raw_hazard, stall_fetch, bubble_ex, mem_store_byp;

    always #2 clk = ~clk;

    raw_bypass_ctl dut (
        .clk(clk), .rst_n(rst_n),
        .id_valid(id_valid), .id_rs(id_rs), .id_rt(id_rt),
        .id_use_rs(id_use_rs), .id_use_rt(id_use_rt), .id_store(id_store),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wen(mem_wen),
        .wb_dst(wb_dst), .wb_wen(wb_wen),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .raw_hazard(raw_hazard), .stall_fetch(stall_fetch),
        .bubble_ex(bubble_ex), .mem_store_byp(mem_store_byp)
    );

    typedef struct {
        logic [1:0] sa;
        logic [1:0] sb;
        logic       hz;
        logic       st;
        logic       byp;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    logic prev_stall;
    logic cand_h1, cand_h2;
    bit   done = 0;

    function automatic logic hit(logic v, logic u, logic [4:0] s, logic [4:0] d, logic w);
        return v && u && (s != 5'd0) && (s == d) && w;
    endfunction

    function automatic logic [1:0] pick(logic he, logic hm, logic ld);
        if (he) return ld ? 2'b00 : 2'b01;
        if (hm) return 2'b10;
        return 2'b00;
    endfunction

    task automatic drive(input logic v, input logic [4:0] rs, input logic [4:0] rt,
                         input logic urs, input logic urt, input logic sto,
                         input logic [4:0] ed, input logic ew, input logic el,
                         input logic [4:0] md, input logic mw,
                         input logic [4:0] wd, input logic ww, input string req);
        exp_t e;
        logic hea, hma, hwa, heb, hmb, hwb, lu, cand;
        @(negedge clk);
        id_valid = v; id_rs = rs; id_rt = rt; id_use_rs = urs; id_use_rt = urt;
        id_store = sto; ex_dst = ed; ex_wen = ew; ex_load = el;
        mem_dst = md; mem_wen = mw; wb_dst = wd; wb_wen = ww;
        hea = hit(v, urs, rs, ed, ew); hma = hit(v, urs, rs, md, mw); hwa = hit(v, urs, rs, wd, ww);
        heb = hit(v, urt, rt, ed, ew); hmb = hit(v, urt, rt, md, mw); hwb = hit(v, urt, rt, wd, ww);
        lu   = el && (hea || (heb && !sto));
        cand = sto && el && heb && !hea;
        e.sa  = pick(hea, hma, el);
        e.sb  = pick(heb, hmb, el);
        e.hz  = hea || hma || hwa || heb || hmb || hwb;
        e.st  = lu && !prev_stall;
        e.byp = cand_h2;
        e.req = req;
        exp_q.push_back(e);
        prev_stall = e.st;
        cand_h2 = cand_h1;
        cand_h1 = cand;
    endtask

    task automatic idle(input string req);
        drive(1'b1, 5'd1, 5'd2, 1'b1, 1'b1, 1'b0, 5'd9, 1'b1, 1'b0,
              5'd10, 1'b1, 5'd11, 1'b1, req);
    endtask

    task automatic cmp(input string req, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // monitor: checks each queued item in the cycle it belongs to
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.req, "fwd_sel_a", int'(fwd_sel_a), int'(e.sa));
                cmp(e.req, "fwd_sel_b", int'(fwd_sel_b), int'(e.sb));
                cmp(e.req, "raw_hazard", int'(raw_hazard), int'(e.hz));
                cmp(e.req, "stall_fetch", int'(stall_fetch), int'(e.st));
                cmp(e.req, "bubble_ex", int'(bubble_ex), int'(e.st));
                cmp(e.req, "mem_store_byp", int'(mem_store_byp), int'(e.byp));
            end
        end
    end

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; prev_stall = 1'b0; cand_h1 = 1'b0; cand_h2 = 1'b0;
        id_valid = 0; id_rs = 0; id_rt = 0; id_use_rs = 0; id_use_rt = 0; id_store = 0;
        ex_dst = 0; ex_wen = 0; ex_load = 0; mem_dst = 0; mem_wen = 0; wb_dst = 0; wb_wen = 0;
        repeat (3) @(negedge clk);
        #1;
        cmp("R10", "mem_store_byp in reset", int'(mem_store_byp), 0);
        cmp("R10", "stall_fetch in reset", int'(stall_fetch), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R10");
        // R1: register 0, write enable off, use flag off
        drive(1, 5'd0, 5'd0, 1, 1, 0, 5'd0, 1, 0, 5'd0, 1, 5'd0, 1, "R1");
        drive(1, 5'd4, 5'd4, 1, 1, 0, 5'd4, 0, 0, 5'd4, 0, 5'd4, 0, "R1");
        drive(1, 5'd4, 5'd5, 0, 0, 0, 5'd4, 1, 1, 5'd5, 1, 5'd4, 1, "R1");
        // R2/R4: writeback-only matches
        drive(1, 5'd6, 5'd7, 1, 1, 0, 5'd1, 1, 0, 5'd2, 1, 5'd6, 1, "R4");
        drive(1, 5'd6, 5'd7, 1, 1, 0, 5'd1, 1, 0, 5'd2, 1, 5'd7, 1, "R2");
        // R3: execute beats memory; memory alone
        drive(1, 5'd8, 5'd8, 1, 1, 0, 5'd8, 1, 0, 5'd8, 1, 5'd8, 1, "R3");
        drive(1, 5'd8, 5'd3, 1, 1, 0, 5'd3, 1, 0, 5'd8, 1, 5'd0, 0, "R3");
        // R5 then R6: load-use on rs, same inputs held
        drive(1, 5'd12, 5'd13, 1, 1, 0, 5'd12, 1, 1, 5'd13, 1, 5'd0, 0, "R5");
        drive(1, 5'd12, 5'd13, 1, 1, 0, 5'd12, 1, 1, 5'd13, 1, 5'd0, 0, "R6");
        // load now in memory stage: forwarded from memory
        drive(1, 5'd12, 5'd13, 1, 1, 0, 5'd20, 1, 0, 5'd12, 1, 5'd0, 0, "R5");
        // R5: load-use on rt of a non-store
        drive(1, 5'd1, 5'd14, 1, 1, 0, 5'd14, 1, 1, 5'd0, 0, 5'd0, 0, "R5");
        idle("R6");
        // R7: store data from load, pulse due two cycles later
        drive(1, 5'd2, 5'd15, 1, 1, 1, 5'd15, 1, 1, 5'd0, 0, 5'd0, 0, "R7");
        idle("R7");
        idle("R7");
        idle("R7");
        // R8: store address depends on load
        drive(1, 5'd16, 5'd16, 1, 1, 1, 5'd16, 1, 1, 5'd0, 0, 5'd0, 0, "R8");
        idle("R8");
        idle("R8");
        idle("R8");
        // R9: invalid decode instruction
        drive(0, 5'd17, 5'd17, 1, 1, 0, 5'd17, 1, 1, 5'd17, 1, 5'd17, 1, "R9");
        // R7 after R5-style store on reset boundary: reset wipes pending pulse (R10)
        drive(1, 5'd2, 5'd18, 1, 1, 1, 5'd18, 1, 1, 5'd0, 0, 5'd0, 0, "R7");
        @(negedge clk);
        #1;
        while (exp_q.size() > 0) #1;
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        cmp("R10", "mem_store_byp after reset", int'(mem_store_byp), 0);
        @(negedge clk);
        #1;
        cmp("R10", "mem_store_byp after reset", int'(mem_store_byp), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule